// File: doc/BRIEF.md
# Feedback IIR Amplitude Servo

This block closes an amplitude loop around a two-channel I/Q transmit datapath. Each channel has a first-order fixed-point IIR filter. A feedback ADC feeds the filter, which advances once per ADC sample strobe. The filter output is a gain in the range zero to just under one. A per-channel multiplier applies that gain to the channel's I and Q words before they reach the DAC. A host programs the servo through a byte-wide register write port. Each channel has one control byte and a bank of sixteen-bit coefficient and offset words. Each word is written as two bytes.

Each channel holds four coefficient profiles. All four profiles of a channel share the two-deep input history, and each profile keeps its own output history. Switching profiles therefore resumes a filter from where it left off. Two modes stop the output from changing. In hold, the filter keeps taking in samples, but its output stays frozen. When a channel is disabled, its multiplier is bypassed and hold is forced.

Each channel's filter is controlled by a three-state machine. IDLE waits for the sample strobe; on a strobe it shifts the input history, snapshots the selected profile and the effective hold, and moves to PROD. PROD registers the three products and the aligned offset, then always moves to ACCUM. ACCUM sums them, shifts the sum, clips it and, unless frozen, writes it to the profile's output register, then always returns to IDLE. A strobe that arrives outside IDLE is ignored.

Top module: `amp_servo`

## Requirements
- R1: After reset every channel is disabled and in hold, profile 0 is selected, all coefficients and offsets are zero, and all output gains are zero. `iq_vld_out` is low, the I and Q outputs are zero, and the channel data passes through unscaled.
- R2: Channel c's control byte is at address 0x30+c. Bit 0 enables the servo, bit 1 requests hold, and bits 3:2 select the active profile.
- R3: Coefficient bytes are at address 0x32 + 32·c + 8·p + 2·k, where k = 0, 1, 2, 3 selects b0, b1, a1 and offset. The high byte sits at the even address. A word changes only when its low byte is written, and it then takes the last high byte written.
- R4: On each accepted update the output is y = clip((a1·y_prev + b0·x_n + b1·x_(n-1) + offset·2^14) >>> 14). All operands are signed 16-bit, and y_prev is the profile's previous output.
- R5: The stored output is clipped to the range 0 to 0x7FFF. A negative result gives 0, and anything above 0x7FFF gives 0x7FFF.
- R6: The four profiles of a channel share x_n and x_(n-1). Each profile keeps its own output, and that output is untouched while another profile is active.
- R7: While hold is set, each strobe still shifts the input history, but the active profile's output is not written.
- R8: While a channel is disabled, its I and Q pass through unscaled and its filter behaves as if hold were set.
- R9: When a channel is enabled, each output equals (input · y) >>> 15 for the signed 16-bit input and the active profile's gain y. `iq_vld_out` follows `iq_vld_in` one cycle later, and the outputs for a valid input appear in that same cycle.
- R10: The filter changes only in response to `adc_stb`. The new output is in place by the third rising edge after the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register byte write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Register byte data |
| adc_stb | input | 1 | ADC sample strobe, one cycle |
| adc_data | input | 32 | Signed feedback samples, channel 0 in bits 15:0 |
| iq_vld_in | input | 1 | I/Q input valid |
| i_in | input | 32 | Signed I words, channel 0 in bits 15:0 |
| q_in | input | 32 | Signed Q words, channel 0 in bits 15:0 |
| iq_vld_out | output | 1 | I/Q output valid |
| i_out | output | 32 | Scaled or bypassed I words |
| q_out | output | 32 | Scaled or bypassed Q words |

## Verification
The hardest situation to reach from the ports is the pair of hidden histories. The shared input history and the per-profile outputs cannot be read directly; each shows up only through a later multiplier result. The stimulus reaches them indirectly. It loads a profile whose only nonzero coefficient is b1, so that profile's output becomes x_(n-1), and it uses an input of -32768 so that the scaled output equals -y exactly. With that setup, the bench switches profiles, holds, releases and makes single-byte writes. Each of these leaves a distinct, predictable trace on the next probe of the datapath.

// File: rtl/servo_pkg.sv
`timescale 1ns/1ps
package servo_pkg;
    localparam int N_CH       = 2;
    localparam int N_PROF     = 4;
    localparam int DATA_W     = 16;
    localparam int COEF_SHIFT = 14;
    localparam int CTRL_BASE  = 8'h30;
    localparam int COEF_BASE  = 8'h32;

    typedef struct packed {
        logic signed [DATA_W-1:0] b0;
        logic signed [DATA_W-1:0] b1;
        logic signed [DATA_W-1:0] a1;
        logic signed [DATA_W-1:0] off;
    } coef_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROD  = 2'd1,
        ST_ACCUM = 2'd2
    } iir_state_t;
endpackage

// File: rtl/servo_regs.sv
`timescale 1ns/1ps
module servo_regs
    import servo_pkg::*;
#(
    parameter int NCH   = N_CH,
    parameter int NPROF = N_PROF,
    localparam int PW   = $clog2(NPROF)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr,
    input  logic [7:0]                      cfg_addr,
    input  logic [7:0]                      cfg_wdata,
    output logic [NCH-1:0]                  ch_en,
    output logic [NCH-1:0]                  ch_hold,
    output logic [NCH-1:0][PW-1:0]          ch_prof,
    output coef_t [NCH-1:0][NPROF-1:0]      coefs
);
    localparam int PROF_SH = 3;
    localparam int CH_SH   = PROF_SH + PW;
    localparam int MAP_END = COEF_BASE + (NCH << CH_SH);

    logic [7:0] stage;
    logic [7:0] rel;
    logic       in_map;
    int         ci;
    int         pi;
    logic [1:0] kf;

    always_comb begin
        rel    = cfg_addr - 8'(COEF_BASE);
        in_map = (int'(cfg_addr) >= COEF_BASE) && (int'(cfg_addr) < MAP_END);
        ci     = int'(rel) >> CH_SH;
        pi     = (int'(rel) >> PROF_SH) & (NPROF - 1);
        kf     = rel[2:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage   <= '0;
            ch_en   <= '0;
            ch_hold <= '1;
            ch_prof <= '0;
            coefs   <= '0;
        end else if (cfg_wr) begin
            for (int c = 0; c < NCH; c++) begin
                if (int'(cfg_addr) == CTRL_BASE + c) begin
                    ch_en[c]   <= cfg_wdata[0];
                    ch_hold[c] <= cfg_wdata[1];
                    ch_prof[c] <= cfg_wdata[2 +: PW];
                end
            end
            if (in_map) begin
                if (!rel[0]) begin
                    stage <= cfg_wdata;
                end else begin
                    for (int c = 0; c < NCH; c++) begin
                        for (int p = 0; p < NPROF; p++) begin
                            if (ci == c && pi == p) begin
                                unique case (kf)
                                    2'd0: coefs[c][p].b0  <= {stage, cfg_wdata};
                                    2'd1: coefs[c][p].b1  <= {stage, cfg_wdata};
                                    2'd2: coefs[c][p].a1  <= {stage, cfg_wdata};
                                    2'd3: coefs[c][p].off <= {stage, cfg_wdata};
                                    default: ;
                                endcase
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/servo_iir.sv
`timescale 1ns/1ps
module servo_iir
    import servo_pkg::*;
#(
    parameter int NPROF = N_PROF,
    parameter int DW    = DATA_W,
    parameter int SHIFT = COEF_SHIFT,
    localparam int PW   = $clog2(NPROF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [DW-1:0]     x_in,
    input  coef_t [NPROF-1:0]        coefs,
    input  logic [PW-1:0]            prof,
    input  logic                     en,
    input  logic                     hold,
    output logic [DW-1:0]            y_act,
    output logic                     y_we
);
    localparam int ACC_W = 2 * DW + 2;
    localparam logic signed [ACC_W-1:0] YMAX = (ACC_W'(1) <<< (DW - 1)) - 1;

    iir_state_t state, nxt;

    logic signed [DW-1:0]      x0, x1, yp;
    coef_t                     cs;
    logic [PW-1:0]             sel;
    logic                      frz;
    logic signed [2*DW-1:0]    p_a, p_b0, p_b1;
    logic signed [ACC_W-1:0]   p_o;
    logic signed [ACC_W-1:0]   sum, shifted;
    logic [DW-1:0]             y_new;
    logic [NPROF-1:0][DW-1:0]  y_mem;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = stb ? ST_PROD : ST_IDLE;
            ST_PROD:  nxt = ST_ACCUM;
            ST_ACCUM: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        sum     = p_a + p_b0 + p_b1 + p_o;
        shifted = sum >>> SHIFT;
        if (sum < 0)              y_new = '0;
        else if (shifted > YMAX)  y_new = YMAX[DW-1:0];
        else                      y_new = shifted[DW-1:0];
        y_we  = (state == ST_ACCUM) && !frz;
        y_act = y_mem[prof];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0    <= '0;
            x1    <= '0;
            yp    <= '0;
            cs    <= '0;
            sel   <= '0;
            frz   <= 1'b1;
            p_a   <= '0;
            p_b0  <= '0;
            p_b1  <= '0;
            p_o   <= '0;
            y_mem <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (stb) begin
                        x1  <= x0;
                        x0  <= x_in;
                        cs  <= coefs[prof];
                        sel <= prof;
                        yp  <= y_mem[prof];
                        frz <= hold | ~en;
                    end
                end
                ST_PROD: begin
                    p_a  <= cs.a1 * yp;
                    p_b0 <= cs.b0 * x0;
                    p_b1 <= cs.b1 * x1;
                    p_o  <= {{(ACC_W-DW){cs.off[DW-1]}}, cs.off} <<< SHIFT;
                end
                ST_ACCUM: begin
                    if (!frz) y_mem[sel] <= y_new;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/servo_scale.sv
`timescale 1ns/1ps
module servo_scale
    import servo_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic                 en,
    input  logic [DW-1:0]        gain,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);
    logic signed [2*DW-1:0] prod;

    assign prod = din * $signed(gain);

    always_ff @(posedge clk) begin
        if (!rst_n)   dout <= '0;
        else if (vld) dout <= en ? prod[2*DW-2 -: DW] : din;
    end
endmodule

// File: rtl/amp_servo.sv
`timescale 1ns/1ps
module amp_servo
    import servo_pkg::*;
#(
    parameter int NCH   = N_CH,
    parameter int NPROF = N_PROF,
    parameter int DW    = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              adc_stb,
    input  logic [NCH*DW-1:0] adc_data,
    input  logic              iq_vld_in,
    input  logic [NCH*DW-1:0] i_in,
    input  logic [NCH*DW-1:0] q_in,
    output logic              iq_vld_out,
    output logic [NCH*DW-1:0] i_out,
    output logic [NCH*DW-1:0] q_out
);
    localparam int PW = $clog2(NPROF);

    logic [NCH-1:0]                 ch_en;
    logic [NCH-1:0]                 ch_hold;
    logic [NCH-1:0][PW-1:0]         ch_prof;
    coef_t [NCH-1:0][NPROF-1:0]     coefs;
    logic [NCH-1:0][DW-1:0]         y_act;
    logic [NCH-1:0]                 y_we;

    servo_regs #(.NCH(NCH), .NPROF(NPROF)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ch_en(ch_en), .ch_hold(ch_hold),
        .ch_prof(ch_prof), .coefs(coefs)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        servo_iir #(.NPROF(NPROF), .DW(DW)) u_iir (
            .clk(clk), .rst_n(rst_n), .stb(adc_stb),
            .x_in(adc_data[c*DW +: DW]), .coefs(coefs[c]),
            .prof(ch_prof[c]), .en(ch_en[c]), .hold(ch_hold[c]),
            .y_act(y_act[c]), .y_we(y_we[c])
        );
        servo_scale #(.DW(DW)) u_si (
            .clk(clk), .rst_n(rst_n), .vld(iq_vld_in), .en(ch_en[c]),
            .gain(y_act[c]), .din(i_in[c*DW +: DW]), .dout(i_out[c*DW +: DW])
        );
        servo_scale #(.DW(DW)) u_sq (
            .clk(clk), .rst_n(rst_n), .vld(iq_vld_in), .en(ch_en[c]),
            .gain(y_act[c]), .din(q_in[c*DW +: DW]), .dout(q_out[c*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iq_vld_out <= 1'b0;
        else        iq_vld_out <= iq_vld_in;
    end
endmodule

// File: rtl/amp_servo_chk.sv
`timescale 1ns/1ps
module amp_servo_chk #(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_stb,
    input logic              iq_vld_in,
    input logic              iq_vld_out,
    input logic [NCH*DW-1:0] i_in,
    input logic [NCH*DW-1:0] i_out,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_hold,
    input logic [NCH-1:0]    y_we,
    input logic [NCH*DW-1:0] y_act
);
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iq_vld_in |=> iq_vld_out);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (iq_vld_in && !ch_en[c]) |=> (i_out[c*DW +: DW] == $past(i_in[c*DW +: DW])));

        p_gain_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !y_act[c*DW + DW - 1]);

        p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            y_we[c] |-> ($past(ch_en[c], 2) && !$past(ch_hold[c], 2)));

        p_strobe_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
            y_we[c] |-> $past(adc_stb, 2));
    end
endmodule

bind amp_servo amp_servo_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_stb(adc_stb), .iq_vld_in(iq_vld_in),
    .iq_vld_out(iq_vld_out), .i_in(i_in), .i_out(i_out), .ch_en(ch_en),
    .ch_hold(ch_hold), .y_we(y_we), .y_act(y_act)
);

// File: tb/amp_servo_tb.sv
`timescale 1ns/1ps
module amp_servo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        adc_stb = 1'b0;
    logic [31:0] adc_data = '0;
    logic        iq_vld_in = 1'b0;
    logic [31:0] i_in = '0;
    logic [31:0] q_in = '0;
    logic        iq_vld_out;
    logic [31:0] i_out, q_out;

    always #2.5 clk = ~clk;

    amp_servo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .adc_stb(adc_stb), .adc_data(adc_data),
        .iq_vld_in(iq_vld_in), .i_in(i_in), .q_in(q_in),
        .iq_vld_out(iq_vld_out), .i_out(i_out), .q_out(q_out)
    );

    typedef struct {
        int    i0, q0, i1, q1;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    int   coef_m [2][4][4];
    int   ym [2][4];
    int   x0m [2];
    int   x1m [2];
    bit   enm [2];
    bit   holdm [2];
    int   profm [2];

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int clip16(longint v);
        if (v < 0) return 0;
        if (v > 32767) return 32767;
        return int'(v);
    endfunction

    function automatic void step(int c, int xn);
        longint acc;
        int p = profm[c];
        x1m[c] = x0m[c];
        x0m[c] = xn;
        if (enm[c] && !holdm[c]) begin
            acc = longint'(coef_m[c][p][2]) * ym[c][p]
                + longint'(coef_m[c][p][0]) * x0m[c]
                + longint'(coef_m[c][p][1]) * x1m[c]
                + longint'(coef_m[c][p][3]) * 16384;
            ym[c][p] = clip16(acc >>> 14);
        end
    endfunction

    function automatic int scl(int c, int v);
        longint pr;
        if (!enm[c]) return v;
        pr = longint'(v) * ym[c][profm[c]];
        return int'(pr >>> 15);
    endfunction

    task automatic wr8(int a, int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic int caddr(int c, int p, int k);
        return 8'h32 + 32 * c + 8 * p + 2 * k;
    endfunction

    task automatic wr16(int c, int p, int k, int v);
        wr8(caddr(c, p, k), (v >> 8) & 8'hFF);
        wr8(caddr(c, p, k) + 1, v & 8'hFF);
        coef_m[c][p][k] = v;
    endtask

    task automatic set_ctrl(int c, bit en, bit hold, int prof);
        wr8(8'h30 + c, (prof << 2) | (int'(hold) << 1) | int'(en));
        enm[c] = en; holdm[c] = hold; profm[c] = prof;
    endtask

    task automatic strobe(int xa, int xb);
        @(negedge clk);
        adc_data = {16'(xb), 16'(xa)};
        adc_stb = 1'b1;
        @(negedge clk);
        adc_stb = 1'b0;
        step(0, xa);
        step(1, xb);
        repeat (4) @(negedge clk);
    endtask

    // driver: pushes the expected scaled words into the scoreboard
    task automatic probe(int i0, int q0, int i1, int q1, string tag);
        exp_t e;
        e.i0 = scl(0, i0); e.q0 = scl(0, q0);
        e.i1 = scl(1, i1); e.q1 = scl(1, q1);
        e.tag = tag;
        @(negedge clk);
        i_in = {16'(i1), 16'(i0)};
        q_in = {16'(q1), 16'(q0)};
        iq_vld_in = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        iq_vld_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops and compares as results appear (R9)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && iq_vld_out) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: unexpected output valid, actual 1 expected 0");
                end else begin
                    exp_t e;
                    int a0, b0, a1, b1;
                    e = exp_q.pop_front();
                    a0 = $signed(i_out[15:0]);  b0 = $signed(q_out[15:0]);
                    a1 = $signed(i_out[31:16]); b1 = $signed(q_out[31:16]);
                    if (a0 != e.i0 || b0 != e.q0 || a1 != e.i1 || b1 != e.q1) begin
                        n_fail++;
                        $display("FAIL %s: actual i0=%0d q0=%0d i1=%0d q1=%0d expected i0=%0d q0=%0d i1=%0d q1=%0d",
                                 e.tag, a0, b0, a1, b1, e.i0, e.q0, e.i1, e.q1);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        foreach (coef_m[c, p, k]) coef_m[c][p][k] = 0;
        foreach (ym[c, p]) ym[c][p] = 0;
        for (int c = 0; c < 2; c++) begin
            x0m[c] = 0; x1m[c] = 0; enm[c] = 0; holdm[c] = 1; profm[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        n_chk++;
        if (iq_vld_out !== 1'b0 || i_out !== '0 || q_out !== '0) begin
            n_fail++;
            $display("FAIL R1: actual vld=%b i=%h q=%h expected vld=0 i=0 q=0", iq_vld_out, i_out, q_out);
        end
        probe(1234, -5, -300, 32767, "R1 reset bypass");

        // R8: disabled channel holds its filter even with nonzero coefficients
        wr16(0, 0, 0, 16'h4000);
        strobe(16'h1000, 16'h0800);
        set_ctrl(0, 1, 0, 0);
        probe(-32768, 16'h4000, 77, -77, "R8 forced hold");

        // R4 / R9: unity b0 gain, scaled outputs
        strobe(16'h2000, 16'h0100);
        probe(-32768, 16'h4000, 5, 6, "R4 R9 gain");

        // R5: clipping at both ends
        strobe(-16'h1000, 0);
        probe(-32768, 1000, 0, 0, "R5 clip low");
        wr16(0, 0, 0, 16'h7FFF);
        strobe(16'h7FFF, 0);
        probe(-32768, -1000, 0, 0, "R5 clip high");

        // R3: the high byte alone does not change the word
        wr8(caddr(0, 0, 0), 8'h20);
        strobe(16'h2000, 0);
        probe(-32768, 0, 0, 0, "R3 staged byte");
        wr8(caddr(0, 0, 0) + 1, 8'h00);
        coef_m[0][0][0] = 16'h2000;
        strobe(16'h2000, 0);
        probe(-32768, 0, 0, 0, "R3 commit");

        // R4: feedback through a1 on profile 1
        wr16(0, 1, 0, 16'h4000);
        wr16(0, 1, 2, 16'h4000);
        set_ctrl(0, 1, 0, 1);
        strobe(16'h1000, 0);
        strobe(16'h1000, 0);
        probe(-32768, 300, 0, 0, "R4 feedback");

        // R6: profile 2 (b1 only) sees the shared input history
        wr16(0, 2, 1, 16'h4000);
        set_ctrl(0, 1, 0, 2);
        strobe(16'h0300, 0);
        probe(-32768, 0, 0, 0, "R6 shared x");
        set_ctrl(0, 1, 0, 0);
        probe(-32768, 0, 0, 0, "R6 separate y");

        // R7: hold freezes y but the input history keeps moving
        set_ctrl(0, 1, 1, 2);
        strobe(16'h0500, 0);
        probe(-32768, 0, 0, 0, "R7 hold frozen");
        strobe(16'h0700, 0);
        set_ctrl(0, 1, 0, 2);
        strobe(16'h0100, 0);
        probe(-32768, 0, 0, 0, "R7 x advanced");

        // R4: offset path on profile 3
        wr16(0, 3, 3, 16'h1234);
        set_ctrl(0, 1, 0, 3);
        strobe(16'h0400, 0);
        probe(-32768, 0, 0, 0, "R4 offset");

        // R2 / R3: channel 1 control and coefficient addresses
        wr16(1, 0, 0, 16'h4000);
        set_ctrl(1, 1, 0, 0);
        strobe(16'h0400, 16'h3000);
        probe(-32768, 0, -32768, 16'h2000, "R2 R3 channel 1");

        // R8: disabling bypasses; re-enabling finds y unchanged
        set_ctrl(0, 0, 0, 3);
        probe(4321, -4321, 0, 0, "R8 bypass");
        strobe(16'h7000, 16'h3000);
        set_ctrl(0, 1, 0, 3);
        probe(-32768, 0, -32768, 0, "R8 y kept");

        // R10: input changes without a strobe do nothing
        @(negedge clk);
        adc_data = {16'h7000, 16'h7000};
        repeat (6) @(negedge clk);
        probe(-32768, 0, -32768, 0, "R10 no strobe");

        repeat (6) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: actual %0d pending results expected 0", exp_q.size());
        end
        summary();
    end
endmodule